// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a 64-bit virtual address into a physical page address by reading translation tables from memory. A one-cycle start pulse carries the virtual address. Run-time configuration inputs give two root table bases, one for each address half, and a shift and width for each of four directory levels and for the final leaf table. The walker reads one 64-bit entry at a time through a request/response memory port. When it finishes it pulses done and presents the physical page address, a writable flag and a fault flag.

A directory level whose width is zero is passed over without a memory access, so shallower table trees need no other configuration. A directory entry that carries the huge marker ends the descent. That entry is rewritten into ordinary leaf form and used in place of a leaf table entry. The configuration inputs must stay stable while a walk is in progress.

Top module: `pt_walker`

## Requirements
- R1: Bit 63 of the virtual address selects the root: 1 selects `root_hi`, 0 selects `root_lo`. The chosen root is truncated to PA_W bits before use.
- R2: Directory levels are visited from level 4 down to level 1. Each entry address is `base | (((va >> shift) & ((1<<width)-1)) << 3)`, truncated to PA_W bits. Index k of the `cfg_dir_*` vectors holds level k+1.
- R3: A directory level whose width is zero causes no memory read, and the walk moves on to the next lower level.
- R4: A fetched directory entry, truncated to PA_W bits, becomes the next base. If bit 6 (huge marker) of that entry is set, the descent stops and no leaf table read is made.
- R5: A huge entry is rewritten before use. Bits [14:13] and bit 6 are cleared. If bit 12 is set, bit 12 is cleared and bit 6 (global) is set.
- R6: If no huge entry is met, exactly one more read is made, at the address formed from `cfg_leaf_shift` and `cfg_leaf_width`. The full 64-bit data returned is the leaf entry.
- R7: If bit 0 (valid) of the leaf entry is clear, done comes with fault=1, phys_addr=0 and writable=0.
- R8: For a valid leaf entry, writable equals bit 1 (dirty) of the entry, and fault is 0.
- R9: For a valid leaf entry, the walker computes `leaf + (va & PA mask & ((1<<s)-1))`. Here s is the shift of the huge level or the leaf shift. Bits 63:61 of the sum are then cleared, and so are its low PAGE_SHIFT bits. phys_addr is the low PA_W bits of the result.
- R10: At most one memory request is outstanding at any time. A request keeps `mem_req_valid` high and `mem_req_addr` stable until `mem_req_ready`. No new request is made before the response arrives.
- R11: A start pulse that arrives while a walk is in progress is ignored.
- R12: After reset, done and mem_req_valid are low. done is high for exactly one cycle per walk, together with that walk's results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle walk request |
| start_va | input | 64 | Virtual address to translate |
| root_lo | input | 64 | Root base for addresses with bit 63 clear |
| root_hi | input | 64 | Root base for addresses with bit 63 set |
| cfg_dir_shift | input | 4x6 | Index shift per directory level |
| cfg_dir_width | input | 4x5 | Index width per directory level, 0 skips the level |
| cfg_leaf_shift | input | 6 | Index shift of the leaf table |
| cfg_leaf_width | input | 5 | Index width of the leaf table |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_addr | output | PA_W | Byte address of the entry to read |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 64 | Read data |
| done | output | 1 | Walk finished, results valid |
| phys_addr | output | PA_W | Page-aligned physical address |
| writable | output | 1 | Page may be written |
| fault | output | 1 | Leaf entry not valid |

## Verification
The sweep runs every combination of enabled and skipped directory levels over a mix of low-half and high-half addresses. A design that read a skipped level, visited levels in the wrong order or ORed the index at the wrong position would show up as a mismatch in the logged request addresses. Memory contents come from a hash, so huge entries turn up at every level. A design that kept the huge marker, the level bits or the huge-global bit, or that added the offset under the leaf shift instead of the huge level's shift, would return a wrong physical address. The memory stalls its ready at random, which catches a request address that moves before it is accepted. A second start sent in mid-walk catches a walker that restarts or pulses done twice.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int NUM_LVL = 4;
    localparam int SHIFT_W = 6;
    localparam int WIDTH_W = 5;
    localparam int LVL_W   = $clog2(NUM_LVL);

    // entry bit positions (decoded by the rest of the memory system)
    localparam int B_VALID   = 0;
    localparam int B_DIRTY   = 1;
    localparam int B_HUGE    = 6;
    localparam int B_GLOBAL  = 6;
    localparam int B_HGLOBAL = 12;
    localparam int B_LVL_LO  = 13;
    localparam int B_LVL_HI  = 14;
    localparam int B_ATTR_LO = 61;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SEL   = 3'd1,
        ST_DREQ  = 3'd2,
        ST_DWAIT = 3'd3,
        ST_LSEL  = 3'd4,
        ST_LREQ  = 3'd5,
        ST_LWAIT = 3'd6
    } ptw_state_e;
endpackage

// File: rtl/ptw_index.sv
module ptw_index
    import ptw_pkg::*;
#(
    parameter int PA_W = 48
) (
    input  logic [PA_W-1:0]    base,
    input  logic [63:0]        va,
    input  logic [SHIFT_W-1:0] shift,
    input  logic [WIDTH_W-1:0] width,
    output logic [PA_W-1:0]    entry_addr
);
    logic [63:0] idx;
    logic [63:0] sum;

    always_comb begin
        idx        = (va >> shift) & ((64'd1 << width) - 64'd1);
        sum        = {{(64-PA_W){1'b0}}, base} | (idx << 3);
        entry_addr = sum[PA_W-1:0];
    end
endmodule

// File: rtl/ptw_leaf.sv
module ptw_leaf
    import ptw_pkg::*;
#(
    parameter int PA_W       = 48,
    parameter int PAGE_SHIFT = 12
) (
    input  logic [63:0]        entry,
    input  logic               is_huge,
    input  logic [63:0]        va,
    input  logic [SHIFT_W-1:0] last_shift,
    output logic [PA_W-1:0]    phys,
    output logic               wr,
    output logic               flt
);
    localparam logic [63:0] PA_MASK = (64'd1 << PA_W) - 64'd1;

    logic [63:0] pte;
    logic [63:0] offs;
    logic [63:0] sum;

    always_comb begin
        pte = entry;
        if (is_huge) begin
            pte[B_LVL_HI:B_LVL_LO] = '0;
            pte[B_HUGE]            = 1'b0;
            if (entry[B_HGLOBAL]) begin
                pte[B_HGLOBAL] = 1'b0;
                pte[B_GLOBAL]  = 1'b1;
            end
        end
        offs = va & PA_MASK & ((64'd1 << last_shift) - 64'd1);
        sum  = pte + offs;
        sum[63:B_ATTR_LO]    = '0;
        sum[PAGE_SHIFT-1:0]  = '0;
        flt  = ~pte[B_VALID];
        wr   = pte[B_VALID] & pte[B_DIRTY];
        phys = pte[B_VALID] ? sum[PA_W-1:0] : '0;
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int PA_W       = 48,
    parameter int PAGE_SHIFT = 12
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start,
    input  logic [63:0]                       start_va,
    input  logic [63:0]                       root_lo,
    input  logic [63:0]                       root_hi,
    input  logic [NUM_LVL-1:0][SHIFT_W-1:0]   cfg_dir_shift,
    input  logic [NUM_LVL-1:0][WIDTH_W-1:0]   cfg_dir_width,
    input  logic [SHIFT_W-1:0]                cfg_leaf_shift,
    input  logic [WIDTH_W-1:0]                cfg_leaf_width,
    output logic                              mem_req_valid,
    output logic [PA_W-1:0]                   mem_req_addr,
    input  logic                              mem_req_ready,
    input  logic                              mem_rsp_valid,
    input  logic [63:0]                       mem_rsp_data,
    output logic                              done,
    output logic [PA_W-1:0]                   phys_addr,
    output logic                              writable,
    output logic                              fault
);
    typedef struct packed {
        ptw_state_e       state;
        logic [LVL_W-1:0] lvl;
        logic [63:0]      va;
        logic [PA_W-1:0]  base;
        logic [PA_W-1:0]  req_addr;
        logic             done;
        logic [PA_W-1:0]  phys;
        logic             wr;
        logic             fault;
    } walk_t;

    walk_t q, d;

    logic [63:0]        root_sel;
    logic [SHIFT_W-1:0] ix_shift;
    logic [WIDTH_W-1:0] ix_width;
    logic [PA_W-1:0]    ent_addr;
    logic [63:0]        lf_entry;
    logic               lf_huge;
    logic [SHIFT_W-1:0] lf_shift;
    logic [PA_W-1:0]    lf_phys;
    logic               lf_wr;
    logic               lf_flt;

    always_comb begin
        ix_shift = (q.state == ST_LSEL) ? cfg_leaf_shift : cfg_dir_shift[q.lvl];
        ix_width = (q.state == ST_LSEL) ? cfg_leaf_width : cfg_dir_width[q.lvl];
        lf_huge  = (q.state == ST_DWAIT);
        lf_entry = lf_huge ? {{(64-PA_W){1'b0}}, mem_rsp_data[PA_W-1:0]} : mem_rsp_data;
        lf_shift = lf_huge ? cfg_dir_shift[q.lvl] : cfg_leaf_shift;
        root_sel = start_va[63] ? root_hi : root_lo;
    end

    ptw_index #(.PA_W(PA_W)) u_index (
        .base       (q.base),
        .va         (q.va),
        .shift      (ix_shift),
        .width      (ix_width),
        .entry_addr (ent_addr)
    );

    ptw_leaf #(.PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT)) u_leaf (
        .entry      (lf_entry),
        .is_huge    (lf_huge),
        .va         (q.va),
        .last_shift (lf_shift),
        .phys       (lf_phys),
        .wr         (lf_wr),
        .flt        (lf_flt)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.va    = start_va;
                    d.base  = root_sel[PA_W-1:0];
                    d.lvl   = LVL_W'(NUM_LVL - 1);
                    d.state = ST_SEL;
                end
            end
            ST_SEL: begin
                if (cfg_dir_width[q.lvl] == '0) begin
                    if (q.lvl == '0) d.state = ST_LSEL;
                    else             d.lvl   = q.lvl - 1'b1;
                end else begin
                    d.req_addr = ent_addr;
                    d.state    = ST_DREQ;
                end
            end
            ST_DREQ: begin
                if (mem_req_ready) d.state = ST_DWAIT;
            end
            ST_DWAIT: begin
                if (mem_rsp_valid) begin
                    d.base = mem_rsp_data[PA_W-1:0];
                    if (mem_rsp_data[B_HUGE]) begin
                        d.done  = 1'b1;
                        d.phys  = lf_phys;
                        d.wr    = lf_wr;
                        d.fault = lf_flt;
                        d.state = ST_IDLE;
                    end else if (q.lvl == '0) begin
                        d.state = ST_LSEL;
                    end else begin
                        d.lvl   = q.lvl - 1'b1;
                        d.state = ST_SEL;
                    end
                end
            end
            ST_LSEL: begin
                d.req_addr = ent_addr;
                d.state    = ST_LREQ;
            end
            ST_LREQ: begin
                if (mem_req_ready) d.state = ST_LWAIT;
            end
            ST_LWAIT: begin
                if (mem_rsp_valid) begin
                    d.done  = 1'b1;
                    d.phys  = lf_phys;
                    d.wr    = lf_wr;
                    d.fault = lf_flt;
                    d.state = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_req_valid = (q.state == ST_DREQ) || (q.state == ST_LREQ);
    assign mem_req_addr  = q.req_addr;
    assign done          = q.done;
    assign phys_addr     = q.phys;
    assign writable      = q.wr;
    assign fault         = q.fault;

    // R10: request held stable until accepted
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R10: no new request while a response is due
    p_single_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> !mem_req_valid);

    // R12: done lasts one cycle
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: faulting walk reports no address and no write permission
    p_fault_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done && fault |-> (phys_addr == '0) && !writable);

    // R11: start during a walk leaves the captured address alone
    p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state != ST_IDLE) && start |=> $stable(q.va));

    // R3: a skipped upper level raises no request
    p_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_SEL) && (cfg_dir_width[q.lvl] == '0) && (q.lvl != '0) |=> !mem_req_valid);
endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
    localparam int PA_W = 48;
    localparam logic [63:0] PA_MASK = (64'd1 << PA_W) - 64'd1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [63:0] start_va = '0;
    logic [63:0] root_lo = 64'hFFFF_0000_0010_0000;
    logic [63:0] root_hi = 64'h0000_0000_0200_0000;
    logic [3:0][5:0] cfg_dir_shift;
    logic [3:0][4:0] cfg_dir_width;
    logic [5:0] cfg_leaf_shift = 6'd12;
    logic [4:0] cfg_leaf_width = 5'd3;
    logic mem_req_valid;
    logic [PA_W-1:0] mem_req_addr;
    logic mem_req_ready = 1'b0;
    logic mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic done;
    logic [PA_W-1:0] phys_addr;
    logic writable;
    logic fault;

    int checks = 0;
    int failures = 0;
    int done_cnt = 0;
    int obs_n = 0;
    logic [PA_W-1:0] obs_addr [0:7];
    int exp_n;
    logic [PA_W-1:0] exp_addr [0:4];

    always #10 clk = ~clk;

    pt_walker #(.PA_W(PA_W), .PAGE_SHIFT(12)) u_dut (.*);

    function automatic logic [63:0] mem_f(input logic [63:0] a);
        logic [63:0] x;
        x = a * 64'h9E37_79B9_7F4A_7C15;
        x = x ^ (x >> 29);
        x = x * 64'hBF58_476D_1CE4_E5B9;
        x = x ^ (x >> 32);
        return x;
    endfunction

    // expected walk, from the requirements
    task automatic model(input logic [63:0] va, output logic [PA_W-1:0] ph,
                         output logic wr, output logic fl, output logic huge);
        logic [63:0] base, pte, idx, e, r;
        logic [63:0] a;
        int sh;
        base = (va[63] ? root_hi : root_lo) & PA_MASK;
        huge = 1'b0; sh = 0; exp_n = 0;
        for (int l = 3; l >= 0; l--) begin
            if (cfg_dir_width[l] == 0) continue;
            idx = (va >> cfg_dir_shift[l]) & ((64'd1 << cfg_dir_width[l]) - 1);
            a = (base | (idx << 3)) & PA_MASK;
            exp_addr[exp_n] = a[PA_W-1:0]; exp_n++;
            e = mem_f(a);
            base = e & PA_MASK;
            if (e[6]) begin huge = 1'b1; sh = int'(cfg_dir_shift[l]); break; end
        end
        if (huge) begin
            pte = base;
            pte[14:13] = 2'b00; pte[6] = 1'b0;
            if (pte[12]) begin pte[12] = 1'b0; pte[6] = 1'b1; end
        end else begin
            idx = (va >> cfg_leaf_shift) & ((64'd1 << cfg_leaf_width) - 1);
            a = (base | (idx << 3)) & PA_MASK;
            exp_addr[exp_n] = a[PA_W-1:0]; exp_n++;
            pte = mem_f(a);
            sh = int'(cfg_leaf_shift);
        end
        if (!pte[0]) begin
            fl = 1'b1; wr = 1'b0; ph = '0;
        end else begin
            fl = 1'b0; wr = pte[1];
            r = pte + (va & PA_MASK & ((64'd1 << sh) - 1));
            r[63:61] = 3'b000; r[11:0] = '0;
            ph = r[PA_W-1:0];
        end
    endtask

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory responder with random stalls; also watches the request rules (R10)
    initial begin
        logic [15:0] lfsr = 16'hACE1;
        logic pending = 1'b0;
        logic [PA_W-1:0] pend_addr = '0;
        logic was_stalled = 1'b0;
        logic [PA_W-1:0] stall_addr = '0;
        forever begin
            @(negedge clk);
            if (was_stalled) begin
                chk(mem_req_valid && (mem_req_addr == stall_addr), "R10 hold",
                    {16'h0, mem_req_addr}, {16'h0, stall_addr});
            end
            if (mem_req_valid && (pending || mem_rsp_valid))
                chk(1'b0, "R10 outstanding", 64'd1, 64'd0);
            if (pending) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem_f({16'h0, pend_addr});
                pending = 1'b0;
            end else begin
                mem_rsp_valid = 1'b0;
                mem_rsp_data  = 64'hDEAD_BEEF_0BAD_F00D;
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_req_ready = lfsr[0] | lfsr[3];
            was_stalled = mem_req_valid && !mem_req_ready;
            stall_addr  = mem_req_addr;
            if (mem_req_valid && mem_req_ready) begin
                pending = 1'b1;
                pend_addr = mem_req_addr;
                if (obs_n < 8) obs_addr[obs_n] = mem_req_addr;
                obs_n++;
            end
        end
    end

    always @(negedge clk) if (done) done_cnt++;

    task automatic pulse_start(input logic [63:0] va);
        @(negedge clk);
        start = 1'b1; start_va = va;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if (done) begin ok = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic run_walk(input logic [63:0] va, input logic [63:0] va2, input bit interrupt);
        logic [PA_W-1:0] eph; logic ewr, efl, ehuge; bit ok; string tag;
        model(va, eph, ewr, efl, ehuge);
        obs_n = 0; done_cnt = 0;
        pulse_start(va);
        if (interrupt) begin
            repeat (2) @(negedge clk);
            start = 1'b1; start_va = va2;
            @(negedge clk);
            start = 1'b0;
        end
        wait_done(ok);
        chk(ok, "R12 done timeout", 64'd0, 64'd1);
        if (!ok) return;
        tag = efl ? "R7" : (ehuge ? "R5 R9" : "R6 R9");
        chk(phys_addr == eph, {tag, " phys_addr"}, {16'h0, phys_addr}, {16'h0, eph});
        chk(fault == efl, "R7 fault", {63'h0, fault}, {63'h0, efl});
        chk(writable == ewr, "R8 writable", {63'h0, writable}, {63'h0, ewr});
        chk(obs_n == exp_n, ehuge ? "R3 R4 read count" : "R3 R6 read count",
            64'(obs_n), 64'(exp_n));
        for (int k = 0; k < exp_n && k < obs_n; k++)
            chk(obs_addr[k] == exp_addr[k], "R1 R2 entry address",
                {16'h0, obs_addr[k]}, {16'h0, exp_addr[k]});
        @(negedge clk);
        chk(!done, "R12 done one cycle", {63'h0, done}, 64'd0);
        if (interrupt) begin
            repeat (8) @(negedge clk);
            chk(done_cnt == 1 && obs_n == exp_n, "R11 start while busy ignored",
                64'(done_cnt), 64'd1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] va;
        cfg_dir_shift = {6'd24, 6'd21, 6'd18, 6'd15};
        cfg_dir_width = '0;
        repeat (3) @(negedge clk);
        chk(!done && !mem_req_valid, "R12 reset state", {62'h0, done, mem_req_valid}, 64'd0);
        rst_n = 1'b1;
        for (int m = 0; m < 16; m++) begin
            for (int l = 0; l < 4; l++)
                cfg_dir_width[l] = m[l] ? 5'(2 + l) : 5'd0;
            for (int i = 0; i < 8; i++) begin
                va = mem_f(64'(m * 16 + i + 7));
                va[63] = i[0];
                run_walk(va, 64'h0, 1'b0);
            end
        end
        // R11: second start mid-walk, full depth
        cfg_dir_width = {5'd3, 5'd3, 5'd3, 5'd3};
        for (int i = 0; i < 4; i++)
            run_walk(mem_f(64'(1000 + i)), mem_f(64'(2000 + i)), 1'b1);
        // R1: same low bits, opposite halves must walk from different roots
        run_walk(64'h0000_0000_0123_4567, 64'h0, 1'b0);
        run_walk(64'h8000_0000_0123_4567, 64'h0, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule